// File: doc/BRIEF.md
# NAND Page Program and Read Sequencer

This block drives the byte-wide bus of a raw NAND flash device for one whole page operation. It gets one start pulse with the operation kind, a page number, a page-size selector and the device's total address-cycle count. From these it issues the opening command, the column and row address bytes and the data stream. It then waits for the device to report ready and, after a program, reads back the device status. Each bus cycle is one clock wide. Two latch strobes mark each written byte as a command, an address or plain data. Read strobes fetch data or status.

A program operation takes its payload from a byte source through a take/valid pair. The payload covers the main area and the spare area of the page. A read operation hands the fetched bytes back on a result port, with a tag that marks spare-area bytes. The payload is always a whole number of 528-byte groups: 512 main bytes followed by 16 spare bytes. Each operation ends with exactly one single-cycle flag: done, timeout or fail.

Top module: `nand_page_seq`

## Requirements
- R1: Each written bus cycle is a command (bus_we with bus_cle), an address (bus_we with bus_ale) or data (bus_we alone). bus_cle and bus_ale are never high together, and bus_we and bus_re are never high together.
- R2: The page_sz encoding is 0 = 512 bytes, 1 = 2048 bytes, 2 or 3 = 4096 bytes. The column part of the address is one 0x00 byte for encoding 0 and two 0x00 bytes otherwise.
- R3: The number of row address bytes is addr_cyc minus the column byte count, limited to the range 2 to 4. Row bytes go out least significant first: page[7:0], page[15:8], page[23:16], page[31:24].
- R4: A program sends command 0x80, then the address, then sectors×528 data bytes (1, 4 or 8 sectors for the page_sz encodings above). It then sends command 0x10, waits for ready, sends command 0x70 and makes exactly one status read.
- R5: A read sends command 0x00 and the address. It sends command 0x30 only when page_sz is not 0. It then waits for ready and makes sectors×528 data reads.
- R6: Each data read byte appears on rd_data with rd_valid one cycle after the cycle its bus_re was high. rd_spare is high for bytes 512 to 527 of every 528-byte group.
- R7: During the wait, nand_rdy is sampled once every POLL_DIV cycles, first one cycle after the wait begins, for at most MAX_POLLS+1 samples. If no sample sees it high, timeout pulses 2+MAX_POLLS×POLL_DIV cycles after the cycle that ends the wait's bus activity, and no further bus cycle is issued. A ready seen at the last sample still completes the operation.
- R8: After a program, status bit 0 set gives fail, and status bit 0 clear gives done. The other status bits are ignored.
- R9: busy rises the cycle after an accepted start and falls in the cycle its single flag pulses. Exactly one of done, timeout and fail pulses per operation, and none pulse outside one.
- R10: A start pulse while busy is ignored. The running operation's bus sequence is unchanged.
- R11: A program data cycle is issued only in a cycle where wr_valid is high, and wr_take marks that byte as consumed. Gaps in wr_valid delay the stream but do not reorder or drop bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (ignored while busy) |
| op_read | input | 1 | 1 = page read, 0 = page program |
| page | input | 32 | Page number |
| page_sz | input | 2 | Page size selector (0:512, 1:2048, 2/3:4096) |
| addr_cyc | input | 3 | Device total address cycle count |
| wr_data | input | 8 | Program payload byte |
| wr_valid | input | 1 | wr_data holds a byte |
| wr_take | output | 1 | wr_data consumed at this clock edge |
| bus_we | output | 1 | Write cycle strobe |
| bus_re | output | 1 | Read cycle strobe |
| bus_cle | output | 1 | Command latch strobe |
| bus_ale | output | 1 | Address latch strobe |
| bus_dout | output | 8 | Byte driven to the device |
| bus_din | input | 8 | Byte returned by the device during bus_re |
| nand_rdy | input | 1 | Device ready level |
| rd_data | output | 8 | Fetched read byte |
| rd_valid | output | 1 | rd_data holds a fetched byte |
| rd_spare | output | 1 | Fetched byte lies in a spare group |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation finished correctly (pulse) |
| timeout | output | 1 | Ready never seen (pulse) |
| fail | output | 1 | Program status reported failure (pulse) |

## Verification
The checks assume three things about the inputs. The device returns bus_din in the same cycle that bus_re is high. wr_data stays stable until the edge where wr_take is high. start is never sampled during reset. The bench's device model meets these: it drives bus_din combinationally from its read counter and its last latched command, and it advances the payload source only on wr_take edges. Ready is held low at each start and raised at a chosen cycle, or never raised, so that the ready samples land on either side of the final poll.

// File: rtl/nand_seq_pkg.sv
`timescale 1ns/1ps
package nand_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CMD, ST_ADDR, ST_RSTART, ST_WDATA, ST_PROG,
    ST_WAIT, ST_RDATA, ST_RDRAIN, ST_SCMD, ST_SREAD, ST_SCAP
  } seq_state_t;

  localparam logic [7:0] OP_DATA_IN = 8'h80;
  localparam logic [7:0] OP_PROGRAM = 8'h10;
  localparam logic [7:0] OP_READ    = 8'h00;
  localparam logic [7:0] OP_READ_GO = 8'h30;
  localparam logic [7:0] OP_STATUS  = 8'h70;

  // number of 512-byte sectors held by one page
  function automatic logic [3:0] sectors_of(input logic [1:0] psz);
    case (psz)
      2'd0:    return 4'd1;
      2'd1:    return 4'd4;
      default: return 4'd8;
    endcase
  endfunction

  function automatic logic [1:0] col_bytes(input logic [1:0] psz);
    return (psz == 2'd0) ? 2'd1 : 2'd2;
  endfunction

  // row byte count: remaining address cycles, kept within 2..4
  function automatic logic [2:0] row_bytes(input logic [2:0] ac, input logic [1:0] col);
    logic [3:0] d;
    d = {1'b0, ac} - {2'b00, col};
    if ({1'b0, ac} < ({2'b00, col} + 4'd2)) return 3'd2;
    else if (d > 4'd4)                       return 3'd4;
    else                                     return d[2:0];
  endfunction

endpackage

// File: rtl/nand_addr_gen.sv
`timescale 1ns/1ps
module nand_addr_gen (
  input  logic [2:0]  idx,
  input  logic [1:0]  col_n,
  input  logic [2:0]  row_n,
  input  logic [31:0] page,
  output logic [7:0]  abyte,
  output logic        alast
);
  logic [2:0]  total;
  logic [2:0]  rsel;
  logic [31:0] shifted;

  assign total   = {1'b0, col_n} + row_n;
  assign rsel    = idx - {1'b0, col_n};
  assign shifted = page >> {rsel, 3'b000};
  // column bytes are always zero (start of page); row bytes low first
  assign abyte   = (idx < {1'b0, col_n}) ? 8'h00 : shifted[7:0];
  assign alast   = (idx == total - 3'd1);
endmodule

// File: rtl/nand_stream_ctr.sv
`timescale 1ns/1ps
module nand_stream_ctr #(
  parameter int SECTOR_BYTES = 512,
  parameter int SPARE_BYTES  = 16,
  parameter int SECT_W       = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              step,
  input  logic [SECT_W-1:0] sectors,
  output logic              in_spare,
  output logic              last
);
  localparam int GROUP = SECTOR_BYTES + SPARE_BYTES;
  localparam int POS_W = $clog2(GROUP);

  logic [POS_W-1:0]  pos;
  logic [SECT_W-1:0] sec;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pos <= '0;
      sec <= '0;
    end else if (step) begin
      if (pos == POS_W'(GROUP - 1)) begin
        pos <= '0;
        sec <= sec + 1'b1;
      end else begin
        pos <= pos + 1'b1;
      end
    end
  end

  assign in_spare = (pos >= POS_W'(SECTOR_BYTES));
  assign last     = (pos == POS_W'(GROUP - 1)) && (sec == sectors - 1'b1);

  // R6: a group wraps back to main-area bytes
  assert_group_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (step && !clr && pos == POS_W'(GROUP - 1)) |=> (pos == '0 && !in_spare));
endmodule

// File: rtl/nand_rdy_poll.sv
`timescale 1ns/1ps
module nand_rdy_poll #(
  parameter int POLL_DIV  = 8,
  parameter int MAX_POLLS = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic rdy,
  output logic ok,
  output logic expired
);
  localparam int DIV_W = (POLL_DIV > 1) ? $clog2(POLL_DIV) : 1;
  localparam int CNT_W = $clog2(MAX_POLLS + 1) + 1;

  logic             active;
  logic [DIV_W-1:0] div;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      div     <= '0;
      cnt     <= '0;
      ok      <= 1'b0;
      expired <= 1'b0;
    end else begin
      ok      <= 1'b0;
      expired <= 1'b0;
      if (arm) begin
        active <= 1'b1;
        div    <= '0;
        cnt    <= '0;
      end else if (active) begin
        div <= (div == DIV_W'(POLL_DIV - 1)) ? '0 : div + 1'b1;
        if (div == '0) begin
          if (rdy) begin
            ok     <= 1'b1;
            active <= 1'b0;
          end else if (cnt == CNT_W'(MAX_POLLS)) begin
            expired <= 1'b1;
            active  <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end

  assert_poll_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(ok && expired));
  assert_poll_armed_R7: assert property (@(posedge clk) disable iff (rst)
    (ok || expired) |-> $past(active));
endmodule

// File: rtl/nand_page_seq.sv
`timescale 1ns/1ps
module nand_page_seq
  import nand_seq_pkg::*;
#(
  parameter int POLL_DIV     = 8,
  parameter int MAX_POLLS    = 100,
  parameter int SECTOR_BYTES = 512,
  parameter int SPARE_BYTES  = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        op_read,
  input  logic [31:0] page,
  input  logic [1:0]  page_sz,
  input  logic [2:0]  addr_cyc,
  input  logic [7:0]  wr_data,
  input  logic        wr_valid,
  output logic        wr_take,
  output logic        bus_we,
  output logic        bus_re,
  output logic        bus_cle,
  output logic        bus_ale,
  output logic [7:0]  bus_dout,
  input  logic [7:0]  bus_din,
  input  logic        nand_rdy,
  output logic [7:0]  rd_data,
  output logic        rd_valid,
  output logic        rd_spare,
  output logic        busy,
  output logic        done,
  output logic        timeout,
  output logic        fail
);
  localparam int SECT_W = 4;

  seq_state_t        st;
  logic              op_q, big_q;
  logic [31:0]       page_q;
  logic [1:0]        col_q;
  logic [2:0]        row_q;
  logic [SECT_W-1:0] sect_q;
  logic [2:0]        idx;
  logic [7:0]        abyte;
  logic              alast;
  logic              in_spare, slast, s_clr, s_step;
  logic              poll_arm, poll_ok, poll_exp;
  logic              rd_pend, rd_spare_pend;

  nand_addr_gen u_addr (
    .idx(idx), .col_n(col_q), .row_n(row_q), .page(page_q),
    .abyte(abyte), .alast(alast)
  );

  assign s_clr  = (st == ST_CMD);
  assign s_step = (st == ST_WDATA && wr_valid) || (st == ST_RDATA);

  nand_stream_ctr #(
    .SECTOR_BYTES(SECTOR_BYTES), .SPARE_BYTES(SPARE_BYTES), .SECT_W(SECT_W)
  ) u_stream (
    .clk(clk), .rst(rst), .clr(s_clr), .step(s_step), .sectors(sect_q),
    .in_spare(in_spare), .last(slast)
  );

  assign poll_arm = (st == ST_PROG) || (st == ST_RSTART) ||
                    (st == ST_ADDR && alast && op_q && !big_q);

  nand_rdy_poll #(.POLL_DIV(POLL_DIV), .MAX_POLLS(MAX_POLLS)) u_poll (
    .clk(clk), .rst(rst), .arm(poll_arm), .rdy(nand_rdy),
    .ok(poll_ok), .expired(poll_exp)
  );

  assign wr_take = (st == ST_WDATA) && wr_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= ST_IDLE;
      op_q          <= 1'b0;
      big_q         <= 1'b0;
      page_q        <= '0;
      col_q         <= 2'd1;
      row_q         <= 3'd2;
      sect_q        <= '0;
      idx           <= '0;
      bus_we        <= 1'b0;
      bus_re        <= 1'b0;
      bus_cle       <= 1'b0;
      bus_ale       <= 1'b0;
      bus_dout      <= '0;
      rd_data       <= '0;
      rd_valid      <= 1'b0;
      rd_spare      <= 1'b0;
      rd_pend       <= 1'b0;
      rd_spare_pend <= 1'b0;
      busy          <= 1'b0;
      done          <= 1'b0;
      timeout       <= 1'b0;
      fail          <= 1'b0;
    end else begin
      bus_we   <= 1'b0;
      bus_re   <= 1'b0;
      bus_cle  <= 1'b0;
      bus_ale  <= 1'b0;
      done     <= 1'b0;
      timeout  <= 1'b0;
      fail     <= 1'b0;
      rd_pend  <= 1'b0;
      rd_valid <= rd_pend;
      rd_spare <= rd_spare_pend;
      if (rd_pend) rd_data <= bus_din;

      case (st)
        ST_IDLE: if (start) begin
          op_q   <= op_read;
          big_q  <= (page_sz != 2'd0);
          page_q <= page;
          col_q  <= col_bytes(page_sz);
          row_q  <= row_bytes(addr_cyc, col_bytes(page_sz));
          sect_q <= sectors_of(page_sz);
          busy   <= 1'b1;
          st     <= ST_CMD;
        end
        ST_CMD: begin
          bus_we   <= 1'b1;
          bus_cle  <= 1'b1;
          bus_dout <= op_q ? OP_READ : OP_DATA_IN;
          idx      <= '0;
          st       <= ST_ADDR;
        end
        ST_ADDR: begin
          bus_we   <= 1'b1;
          bus_ale  <= 1'b1;
          bus_dout <= abyte;
          idx      <= idx + 3'd1;
          if (alast) begin
            if (!op_q)     st <= ST_WDATA;
            else if (big_q) st <= ST_RSTART;
            else           st <= ST_WAIT;
          end
        end
        ST_RSTART: begin
          bus_we   <= 1'b1;
          bus_cle  <= 1'b1;
          bus_dout <= OP_READ_GO;
          st       <= ST_WAIT;
        end
        ST_WDATA: if (wr_valid) begin
          bus_we   <= 1'b1;
          bus_dout <= wr_data;
          if (slast) st <= ST_PROG;
        end
        ST_PROG: begin
          bus_we   <= 1'b1;
          bus_cle  <= 1'b1;
          bus_dout <= OP_PROGRAM;
          st       <= ST_WAIT;
        end
        ST_WAIT: begin
          if (poll_ok) begin
            st <= op_q ? ST_RDATA : ST_SCMD;
          end else if (poll_exp) begin
            timeout <= 1'b1;
            busy    <= 1'b0;
            st      <= ST_IDLE;
          end
        end
        ST_RDATA: begin
          bus_re        <= 1'b1;
          rd_pend       <= 1'b1;
          rd_spare_pend <= in_spare;
          if (slast) st <= ST_RDRAIN;
        end
        ST_RDRAIN: begin
          done <= 1'b1;
          busy <= 1'b0;
          st   <= ST_IDLE;
        end
        ST_SCMD: begin
          bus_we   <= 1'b1;
          bus_cle  <= 1'b1;
          bus_dout <= OP_STATUS;
          st       <= ST_SREAD;
        end
        ST_SREAD: begin
          bus_re <= 1'b1;
          st     <= ST_SCAP;
        end
        ST_SCAP: begin
          fail <= bus_din[0];
          done <= !bus_din[0];
          busy <= 1'b0;
          st   <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_strobe_excl_R1: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && bus_re) && !(bus_cle && bus_ale));
  assert_latch_needs_we_R1: assert property (@(posedge clk) disable iff (rst)
    (bus_cle || bus_ale) |-> bus_we);
  assert_rd_after_re_R6: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(bus_re));
  assert_quiet_after_to_R7: assert property (@(posedge clk) disable iff (rst)
    timeout |=> (!bus_we && !bus_re));
  assert_one_flag_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done, timeout, fail}));
  assert_busy_fall_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (done || timeout || fail));
  assert_flag_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (done || timeout || fail) |-> (!busy && $past(busy)));
  assert_take_data_R11: assert property (@(posedge clk) disable iff (rst)
    wr_take |=> (bus_we && !bus_cle && !bus_ale && bus_dout == $past(wr_data)));
endmodule

// File: tb/nand_page_seq_bench.sv
`timescale 1ns/1ps
module nand_page_seq_bench;
  localparam int PD = 8;
  localparam int MP = 100;
  localparam int GRP = 528;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        start = 1'b0, op_read = 1'b0, wr_valid = 1'b1, nand_rdy = 1'b0;
  logic [31:0] page = '0;
  logic [1:0]  page_sz = '0;
  logic [2:0]  addr_cyc = 3'd4;
  logic [7:0]  wr_data, bus_din, bus_dout, rd_data;
  logic        wr_take, bus_we, bus_re, bus_cle, bus_ale, rd_valid, rd_spare;
  logic        busy, done, timeout, fail;

  nand_page_seq #(.POLL_DIV(PD), .MAX_POLLS(MP)) u_nand_page_seq (
    .clk(clk), .rst(rst), .start(start), .op_read(op_read), .page(page),
    .page_sz(page_sz), .addr_cyc(addr_cyc), .wr_data(wr_data),
    .wr_valid(wr_valid), .wr_take(wr_take), .bus_we(bus_we), .bus_re(bus_re),
    .bus_cle(bus_cle), .bus_ale(bus_ale), .bus_dout(bus_dout),
    .bus_din(bus_din), .nand_rdy(nand_rdy), .rd_data(rd_data),
    .rd_valid(rd_valid), .rd_spare(rd_spare), .busy(busy), .done(done),
    .timeout(timeout), .fail(fail)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] pat(int i);
    return 8'(i * 7 + (i >> 8) * 3 + 1);
  endfunction

  // device model
  logic [7:0] last_cmd = 8'hFF;
  logic [7:0] status_val = 8'h00;
  int dev_rd = 0, src_idx = 0;
  logic stall_en = 1'b0;
  always @(posedge clk) begin
    if (bus_we && bus_cle) begin
      last_cmd <= bus_dout;
      dev_rd   <= 0;
      src_idx  <= 0;
    end else begin
      if (bus_re && last_cmd != 8'h70) dev_rd <= dev_rd + 1;
      if (wr_take) src_idx <= src_idx + 1;
    end
  end
  assign bus_din = (last_cmd == 8'h70) ? status_val : pat(dev_rd);
  assign wr_data = pat(src_idx) ^ 8'h5A;
  always @(negedge clk) wr_valid <= stall_en ? (cyc % 3 != 0) : 1'b1;

  // bus monitor
  logic [7:0] cmd_log [16];
  logic [7:0] addr_log[16];
  int n_cmd, n_addr, n_wd, n_rd, n_rv, n_st, err_wd, err_rv, prog_cyc;
  always @(negedge clk) if (!rst) begin
    if (bus_we && bus_cle) begin
      if (n_cmd < 16) cmd_log[n_cmd] = bus_dout;
      n_cmd++;
      if (bus_dout == 8'h10) prog_cyc = cyc;
    end else if (bus_we && bus_ale) begin
      if (n_addr < 16) addr_log[n_addr] = bus_dout;
      n_addr++;
    end else if (bus_we) begin
      if (bus_dout != (pat(n_wd) ^ 8'h5A)) err_wd++;
      n_wd++;
    end
    if (bus_re) begin
      if (last_cmd == 8'h70) n_st++; else n_rd++;
    end
    if (rd_valid) begin
      if (rd_data != pat(n_rv) || rd_spare != ((n_rv % GRP) >= 512)) err_rv++;
      n_rv++;
    end
  end

  int n_chk = 0, n_bad = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  logic got_done, got_to, got_fail;
  int fl_cyc;

  // rmode: 0 = ready after rdly cycles from start, 1 = never, 2 = at last poll
  task automatic run(input bit rd, input logic [1:0] psz, input logic [2:0] ac,
                     input logic [31:0] pg, input int rmode, input int rdly,
                     input logic [7:0] stat, input bit stall, input bit extra);
    int st_cyc;
    @(posedge clk); #1;
    n_cmd = 0; n_addr = 0; n_wd = 0; n_rd = 0; n_rv = 0; n_st = 0;
    err_wd = 0; err_rv = 0; prog_cyc = -1;
    nand_rdy = 1'b0; status_val = stat; stall_en = stall;
    @(negedge clk);
    op_read = rd; page_sz = psz; addr_cyc = ac; page = pg; start = 1'b1;
    st_cyc = cyc;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R9 busy after start", int'(busy), 1);
    while (!(done || timeout || fail)) begin
      if (rmode == 0 && cyc >= st_cyc + rdly) nand_rdy = 1'b1;
      if (rmode == 2 && prog_cyc >= 0 && cyc == prog_cyc + MP * PD - 2) nand_rdy = 1'b1;
      if (extra && cyc == st_cyc + 5) begin start = 1'b1; op_read = ~rd; end
      else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    got_done = done; got_to = timeout; got_fail = fail; fl_cyc = cyc;
    chk(busy == 1'b0, "R9 busy drops with flag", int'(busy), 0);
    repeat (3) @(negedge clk);
    stall_en = 1'b0;
  endtask

  task automatic chk_addr(input logic [1:0] psz, input logic [2:0] ac, input logic [31:0] pg);
    int col, row;
    logic [7:0] e;
    col = (psz == 2'd0) ? 1 : 2;
    row = int'(ac) - col;
    if (row < 2) row = 2;
    if (row > 4) row = 4;
    chk(n_addr == col + row, "R2/R3 address byte count", n_addr, col + row);
    for (int i = 0; i < col + row && i < 16; i++) begin
      e = (i < col) ? 8'h00 : pg[8*(i-col) +: 8];
      chk(addr_log[i] == e, (i < col) ? "R2 column byte" : "R3 row byte", int'(addr_log[i]), int'(e));
    end
  endtask

  task automatic t_reset;
    chk(busy == 0 && done == 0, "R9 reset busy/done", int'({busy, done}), 0);
    chk(timeout == 0 && fail == 0, "R9 reset timeout/fail", int'({timeout, fail}), 0);
    chk(bus_we == 0 && bus_re == 0, "R1 reset bus idle", int'({bus_we, bus_re}), 0);
  endtask

  task automatic t_prog_small;  // status other bits set, bit0 clear
    run(1'b0, 2'd0, 3'd4, 32'h00ABCDEF, 0, 40, 8'hFE, 1'b0, 1'b0);
    chk(got_done && !got_fail, "R8 bit0 clear gives done", int'({got_done, got_fail}), 2);
    chk(n_cmd == 3, "R4 command count", n_cmd, 3);
    chk(cmd_log[0] == 8'h80, "R4 first command", int'(cmd_log[0]), 'h80);
    chk(cmd_log[1] == 8'h10, "R4 program command", int'(cmd_log[1]), 'h10);
    chk(cmd_log[2] == 8'h70, "R4 status command", int'(cmd_log[2]), 'h70);
    chk_addr(2'd0, 3'd4, 32'h00ABCDEF);
    chk(n_wd == GRP, "R4 data byte count", n_wd, GRP);
    chk(err_wd == 0, "R4 data byte values", err_wd, 0);
    chk(n_st == 1, "R4 one status read", n_st, 1);
  endtask

  task automatic t_prog_big_fail;
    run(1'b0, 2'd1, 3'd5, 32'h12345678, 0, 25, 8'hC1, 1'b0, 1'b0);
    chk(got_fail && !got_done, "R8 bit0 set gives fail", int'({got_fail, got_done}), 2);
    chk_addr(2'd1, 3'd5, 32'h12345678);
    chk(n_wd == 4 * GRP, "R4 large page data count", n_wd, 4 * GRP);
    chk(err_wd == 0, "R4 large page data values", err_wd, 0);
  endtask

  task automatic t_read_big;
    run(1'b1, 2'd2, 3'd7, 32'hA1B2C3D4, 0, 30, 8'h00, 1'b0, 1'b0);
    chk(got_done, "R5 read done", int'(got_done), 1);
    chk(n_cmd == 2 && cmd_log[0] == 8'h00, "R5 read command", int'(cmd_log[0]), 0);
    chk(cmd_log[1] == 8'h30, "R5 read start command", int'(cmd_log[1]), 'h30);
    chk_addr(2'd2, 3'd7, 32'hA1B2C3D4);
    chk(n_rd == 8 * GRP, "R5 read cycle count", n_rd, 8 * GRP);
    chk(n_rv == 8 * GRP, "R6 returned byte count", n_rv, 8 * GRP);
    chk(err_rv == 0, "R6 returned values and spare tags", err_rv, 0);
  endtask

  task automatic t_read_small;
    run(1'b1, 2'd0, 3'd2, 32'h00000A5C, 0, 12, 8'h00, 1'b0, 1'b0);
    chk(got_done, "R5 small read done", int'(got_done), 1);
    chk(n_cmd == 1, "R5 no read start on small page", n_cmd, 1);
    chk_addr(2'd0, 3'd2, 32'h00000A5C);
    chk(n_rv == GRP && err_rv == 0, "R6 small read stream", n_rv, GRP);
  endtask

  task automatic t_timeout;
    run(1'b0, 2'd0, 3'd3, 32'h00000077, 1, 0, 8'h00, 1'b0, 1'b0);
    chk(got_to && !got_done && !got_fail, "R7 timeout flag", int'({got_to, got_done, got_fail}), 4);
    chk(fl_cyc - prog_cyc == 2 + MP * PD, "R7 timeout delay", fl_cyc - prog_cyc, 2 + MP * PD);
    chk(n_cmd == 2 && n_st == 0, "R7 no status after timeout", n_cmd, 2);
  endtask

  task automatic t_late_ready;
    run(1'b0, 2'd0, 3'd3, 32'h00000011, 2, 0, 8'h00, 1'b0, 1'b0);
    chk(got_done && !got_to, "R7 ready at last poll completes", int'({got_done, got_to}), 2);
  endtask

  task automatic t_busy_ignore;
    run(1'b0, 2'd0, 3'd4, 32'h00000321, 0, 20, 8'h00, 1'b0, 1'b1);
    chk(got_done, "R10 original op completes", int'(got_done), 1);
    chk(n_cmd == 3 && cmd_log[0] == 8'h80, "R10 second start ignored", n_cmd, 3);
    chk(n_rd == 0 && n_wd == GRP, "R10 no read cycles", n_rd, 0);
  endtask

  task automatic t_stall;
    run(1'b0, 2'd0, 3'd4, 32'h00004455, 0, 10, 8'h00, 1'b1, 1'b0);
    chk(got_done, "R11 stalled program done", int'(got_done), 1);
    chk(n_wd == GRP, "R11 stalled data count", n_wd, GRP);
    chk(err_wd == 0, "R11 stalled data order", err_wd, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_prog_small();
    t_prog_big_fail();
    t_read_big();
    t_read_small();
    t_timeout();
    t_late_ready();
    t_busy_ignore();
    t_stall();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule